// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block computes one multiplication at a time, optionally summed into a 64-bit accumulator. It offers four operation kinds: a 16 by 16 multiply, a 16 by 16 multiply added into the accumulator, a 32 by 32 multiply, and a 32 by 32 multiply added into the accumulator. Each kind can treat its operands as two's-complement or as unsigned values. A host presents two operands and an opcode together with a one-cycle start pulse. It then waits while `busy` is high and picks up the 64-bit result in the cycle that `done` pulses. The same result also appears on the two accumulator words, `acc_hi` and `acc_lo`.

The second operand is consumed in slices, one slice per cycle. Slices are 8 bits wide for the narrow operations and 16 bits wide for the wide ones. When the upper slice carries no information, because it only repeats the sign or is zero, that step is skipped. The operation therefore takes a short or a long number of cycles depending on the data. The wide operations add one result-assembly cycle, and the accumulate forms add one summation cycle.

A separate clear input zeroes the accumulator. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `itermac`

## Requirements
- R1: Opcode bit 0 selects accumulate, bit 1 selects the 32 by 32 width (when clear, only bits 15:0 of `opa` and `opb` are used), and bit 2 selects unsigned operands (when clear, the operands are two's-complement).
- R2: A 16 by 16 multiply yields the exact product of the two 16-bit operands, sign-extended (signed) or zero-extended (unsigned) to 64 bits. This value goes to `result` and to the accumulator.
- R3: A 32 by 32 multiply yields the exact 64-bit product on `result` and in the accumulator.
- R4: An accumulate operation yields the accumulator value plus the product, modulo 2^64. Both `result` and the accumulator take that sum.
- R5: For a 16 by 16 operation, `busy` stays high for 1 cycle when the upper byte of `opb` is redundant, and for 2 cycles otherwise. Redundant means: for signed operands, bits 15:7 are all equal; for unsigned operands, bits 15:8 are all zero. The accumulate form adds 1 cycle.
- R6: For a 32 by 32 operation, `busy` stays high for 2 cycles when the upper half of `opb` is redundant, and for 3 cycles otherwise. Redundant means: for signed operands, bits 31:15 are all equal; for unsigned operands, bits 31:16 are all zero. The accumulate form adds 1 cycle, for at most 4.
- R7: A start pulse sampled while `busy` is low is accepted, and `busy` is high in the next cycle.
- R8: A start pulse sampled while `busy` is high is ignored. This also means operand and opcode changes during an operation do not alter its result, and no second operation begins.
- R9: In the cycle after the last busy cycle, `done` is high for exactly one cycle. In that same cycle `result` and the accumulator show the new value. The accumulator does not change at any other time.
- R10: `acc_clr` zeroes both accumulator words at the next clock edge. When it coincides with a completing operation, the clear wins, while `result` still carries the computed value.
- R11: After reset, `busy` and `done` are low, and `result`, `acc_hi` and `acc_lo` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Opcode: bit 0 accumulate, bit 1 wide, bit 2 unsigned |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier, consumed in slices |
| acc_clr | input | 1 | Zero the accumulator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result of the last completed operation |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |

## Verification
The assertions rely on two conditions. First, the opcode decode always produces a cycle count between one and four. Second, `start` and `acc_clr` are sampled on rising edges, free of glitches between edges.

They make no assumption about when `start` arrives. Starts raised during busy cycles are therefore legal stimulus, and the bench injects them deliberately, with scrambled operands, into the first busy cycle of some operations. The bench changes all inputs only on falling edges. It raises `acc_clr` either while the unit is idle or exactly on the completing edge. A clear never lands in the middle of an accumulate operation, so the accumulator value that the operation reads is always the one the bench expects.

// File: rtl/itermac_pkg.sv
package itermac_pkg;
  // opcode fields, MSB first: unsigned, wide, accumulate
  typedef struct packed {
    logic is_uns;
    logic is_wide;
    logic is_acc;
  } mac_op_t;

  // width of the phase and cycle-count registers (max count is 4)
  localparam int unsigned PH_W = 3;
endpackage

// File: rtl/itermac_plan.sv
// Decodes an incoming request: operand extension and cycle count.
module itermac_plan
  import itermac_pkg::*;
#(
  parameter int unsigned HW = 16
) (
  input  mac_op_t           op,
  input  logic [2*HW-1:0]   opa,
  input  logic [2*HW-1:0]   opb,
  output logic [2*HW:0]     a_ext,
  output logic              two_step,
  output logic [PH_W-1:0]   n_cyc
);
  localparam int unsigned FW = 2 * HW;
  localparam int unsigned CN = HW / 2;

  logic fit;

  always_comb begin
    if (op.is_wide) begin
      a_ext = op.is_uns ? {1'b0, opa} : {opa[FW-1], opa};
      fit   = op.is_uns ? (opb[FW-1:HW] == '0)
                        : ((opb[FW-1:HW-1] == '0) || (opb[FW-1:HW-1] == '1));
    end else begin
      a_ext = op.is_uns ? {{(HW+1){1'b0}}, opa[HW-1:0]}
                        : {{(HW+1){opa[HW-1]}}, opa[HW-1:0]};
      fit   = op.is_uns ? (opb[HW-1:CN] == '0)
                        : ((opb[HW-1:CN-1] == '0) || (opb[HW-1:CN-1] == '1));
    end
    two_step = ~fit;
    n_cyc    = PH_W'(1) + PH_W'(two_step) + PH_W'(op.is_wide) + PH_W'(op.is_acc);
  end
endmodule

// File: rtl/itermac_seq.sv
// Busy/phase sequencer and completion pulse.
module itermac_seq
  import itermac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PH_W-1:0] n_cyc,
  output logic            busy,
  output logic            done,
  output logic            accept,
  output logic            last,
  output logic [PH_W-1:0] ph
);
  logic            busy_q, busy_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] tot_q, tot_d;
  logic            done_q, done_d;
  logic            st_en;

  assign accept = start & ~busy_q;
  assign last   = busy_q & (ph_q == (tot_q - PH_W'(1)));
  assign st_en  = accept | busy_q;

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    tot_d  = tot_q;
    if (accept) begin
      busy_d = 1'b1;
      ph_d   = '0;
      tot_d  = n_cyc;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      ph_d = ph_q + PH_W'(1);
    end
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (st_en) begin
        busy_q <= busy_d;
        ph_q   <= ph_d;
        tot_q  <= tot_d;
      end
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign ph   = ph_q;

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && ph_q == '0));

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && ph_q == $past(ph_q) + PH_W'(1) && tot_q == $past(tot_q)));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tot_q >= PH_W'(1) && tot_q <= PH_W'(4)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/itermac_lane.sv
// Slice multiplier: one signed (2HW+1) x (HW+1) product per cycle, shifted into the partial sum.
module itermac_lane
  import itermac_pkg::*;
#(
  parameter int unsigned HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            busy,
  input  logic            last,
  input  logic [PH_W-1:0] ph,
  input  mac_op_t         op,
  input  logic [2*HW:0]   a_ext,
  input  logic            two_step,
  input  logic [2*HW-1:0] opb,
  input  logic [4*HW-1:0] acc_val,
  output logic [4*HW-1:0] fin
);
  localparam int unsigned FW    = 2 * HW;
  localparam int unsigned AW    = 4 * HW;
  localparam int unsigned CN    = HW / 2;
  localparam int unsigned PW    = FW + HW + 2;
  localparam int unsigned SH_W  = $clog2(HW) + 1;

  logic [FW:0]   a_q;
  logic [FW-1:0] b_q;
  logic          uns_q, wide_q, two_q, accop_q;
  logic [AW-1:0] p_q, p_d;

  logic          hi_step, mul_step, ext_ok;
  logic [HW-1:0] raw_w;
  logic [CN-1:0] raw_n;
  logic [HW:0]   chunk;
  logic [SH_W-1:0] sh;
  logic [PW-1:0] prod;
  logic [AW-1:0] prod_x, term, base;

  always_comb begin
    hi_step  = (ph == PH_W'(1));
    mul_step = busy & ((ph == '0) | (hi_step & two_q));
    ext_ok   = ~uns_q & (hi_step | ~two_q);
    raw_w    = hi_step ? b_q[FW-1:HW] : b_q[HW-1:0];
    raw_n    = hi_step ? b_q[HW-1:CN] : b_q[CN-1:0];
    if (wide_q) begin
      chunk = {ext_ok & raw_w[HW-1], raw_w};
      sh    = hi_step ? SH_W'(HW) : '0;
    end else begin
      chunk = {{(HW+1-CN){ext_ok & raw_n[CN-1]}}, raw_n};
      sh    = hi_step ? SH_W'(CN) : '0;
    end
    prod   = $signed({{(HW+1){a_q[FW]}}, a_q}) * $signed({{(FW+1){chunk[HW]}}, chunk});
    prod_x = {{(AW-PW){prod[PW-1]}}, prod};
    term   = prod_x << sh;
    base   = (ph == '0) ? '0 : p_q;
    p_d    = mul_step ? (base + term) : p_q;
    fin    = p_d + ((accop_q & last) ? acc_val : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      uns_q   <= 1'b0;
      wide_q  <= 1'b0;
      two_q   <= 1'b0;
      accop_q <= 1'b0;
    end else if (accept) begin
      a_q     <= a_ext;
      b_q     <= opb;
      uns_q   <= op.is_uns;
      wide_q  <= op.is_wide;
      two_q   <= two_step;
      accop_q <= op.is_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else if (busy) begin
      p_q <= p_d;
    end
  end

  // an accumulate operation never finishes on a multiply step (R4 summation cycle)
  assert_acc_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && accop_q) |-> !mul_step);

  // a narrow operation uses at most two slice steps (R5)
  assert_narrow_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q && !accop_q) |-> (ph <= PH_W'(1)));
endmodule

// File: rtl/itermac_acc.sv
// Accumulator and result registers.
module itermac_acc #(
  parameter int unsigned HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            last,
  input  logic [4*HW-1:0] fin,
  output logic [4*HW-1:0] acc,
  output logic [4*HW-1:0] res
);
  localparam int unsigned AW = 4 * HW;

  logic [AW-1:0] acc_q, acc_d, res_q;
  logic          acc_en;

  always_comb begin
    acc_en = clr | last;
    if (clr)       acc_d = '0;
    else if (last) acc_d = fin;
    else           acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (last) begin
      res_q <= fin;
    end
  end

  assign acc = acc_q;
  assign res = res_q;

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !last) |=> $stable(acc_q));
endmodule

// File: rtl/itermac.sv
module itermac
  import itermac_pkg::*;
#(
  parameter int unsigned HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [2*HW-1:0] opa,
  input  logic [2*HW-1:0] opb,
  input  logic            acc_clr,
  output logic            busy,
  output logic            done,
  output logic [4*HW-1:0] result,
  output logic [2*HW-1:0] acc_hi,
  output logic [2*HW-1:0] acc_lo
);
  localparam int unsigned FW = 2 * HW;
  localparam int unsigned AW = 4 * HW;

  logic [1:0]      rs_q;
  logic            rst_ns;
  mac_op_t         op_s;
  logic [FW:0]     a_ext;
  logic            two_step;
  logic [PH_W-1:0] n_cyc, ph;
  logic            accept, last;
  logic [AW-1:0]   fin, acc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  assign op_s = mac_op_t'(op);

  itermac_plan #(.HW(HW)) u_plan (
    .op(op_s), .opa(opa), .opb(opb),
    .a_ext(a_ext), .two_step(two_step), .n_cyc(n_cyc)
  );

  itermac_seq u_seq (
    .clk(clk), .rst_n(rst_ns), .start(start), .n_cyc(n_cyc),
    .busy(busy), .done(done), .accept(accept), .last(last), .ph(ph)
  );

  itermac_lane #(.HW(HW)) u_lane (
    .clk(clk), .rst_n(rst_ns), .accept(accept), .busy(busy), .last(last),
    .ph(ph), .op(op_s), .a_ext(a_ext), .two_step(two_step), .opb(opb),
    .acc_val(acc), .fin(fin)
  );

  itermac_acc #(.HW(HW)) u_acc (
    .clk(clk), .rst_n(rst_ns), .clr(acc_clr), .last(last), .fin(fin),
    .acc(acc), .res(result)
  );

  assign acc_hi = acc[AW-1:FW];
  assign acc_lo = acc[FW-1:0];

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !busy);
endmodule

// File: tb/itermac_tb.sv
module itermac_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, acc_clr;
  logic [2:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic        busy, done;
  logic [63:0] result;
  logic [31:0] acc_hi, acc_lo;

  int nvec = 0;
  int nbad = 0;
  logic [63:0] model_acc = '0;

  always #2.5 clk = ~clk;

  itermac u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .opa(opa_i), .opb(opb_i),
    .acc_clr(acc_clr), .busy(busy), .done(done), .result(result),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h0000_007F;
      3:  return 32'h0000_0080;
      4:  return 32'h0000_00FF;
      5:  return 32'h0000_0100;
      6:  return 32'h0000_7FFF;
      7:  return 32'h0000_8000;
      8:  return 32'hFFFF_FF80;
      9:  return 32'hFFFF_FF7F;
      10: return 32'hFFFF_FFFF;
      11: return 32'h0000_FFFF;
      12: return 32'hFFFF_8000;
      13: return 32'hFFFF_7FFF;
      14: return 32'h8000_0000;
      default: return 32'h1234_5678;
    endcase
  endfunction

  // R1 field decode, R2/R3 exact products
  function automatic logic [63:0] model_prod(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    if (op[1]) begin
      ea = op[2] ? {32'b0, a} : {{32{a[31]}}, a};
      eb = op[2] ? {32'b0, b} : {{32{b[31]}}, b};
    end else begin
      ea = op[2] ? {48'b0, a[15:0]} : {{48{a[15]}}, a[15:0]};
      eb = op[2] ? {48'b0, b[15:0]} : {{48{b[15]}}, b[15:0]};
    end
    return ea * eb;
  endfunction

  // R5/R6 busy-cycle counts
  function automatic int model_lat(input logic [2:0] op, input logic [31:0] b);
    bit fit;
    int n;
    if (op[1]) begin
      fit = op[2] ? (b[31:16] == 16'h0) : (b[31:15] == 17'h0 || b[31:15] == 17'h1FFFF);
      n = fit ? 2 : 3;
    end else begin
      fit = op[2] ? (b[15:8] == 8'h0) : (b[15:7] == 9'h0 || b[15:7] == 9'h1FF);
      n = fit ? 1 : 2;
    end
    return n + (op[0] ? 1 : 0);
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, input bit clr_last);
    int lat, cnt;
    logic [63:0] prod, exp_res;
    string rtag;
    lat = model_lat(op, b);
    prod = model_prod(op, a, b);
    exp_res = op[0] ? (model_acc + prod) : prod;
    rtag = op[0] ? "R1/R4" : (op[1] ? "R1/R3" : "R1/R2");
    @(negedge clk);
    start = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    cnt = 0;
    while (busy === 1'b1 && cnt < 8) begin
      cnt++;
      chk(done === 1'b0, "R9 done low while busy", 64'(done), 64'd0);
      if (cnt == 1 && poke) begin
        start = 1'b1; opa_i = ~a; opb_i = ~b; op_i = op ^ 3'b011;   // R8 ignored request
      end else begin
        start = 1'b0;
      end
      acc_clr = (clr_last && cnt == lat);
      @(negedge clk);
    end
    start = 1'b0;
    acc_clr = 1'b0;
    chk(cnt == lat, op[1] ? "R6 latency" : "R5 latency", 64'(cnt), 64'(lat));
    chk(done === 1'b1, "R9 done pulse", 64'(done), 64'd1);
    chk(result === exp_res, rtag, result, exp_res);
    model_acc = clr_last ? 64'h0 : exp_res;
    chk({acc_hi, acc_lo} === model_acc, clr_last ? "R10 clear wins" : "R9 acc update",
        {acc_hi, acc_lo}, model_acc);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, poke ? "R8 no second op" : "R9 single pulse",
        {62'b0, busy, done}, 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nvec, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; acc_clr = 1'b0;
    op_i = '0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0 && done === 1'b0, "R11 flags", {62'b0, busy, done}, 64'd0);
    chk(result === 64'h0, "R11 result", result, 64'h0);
    chk({acc_hi, acc_lo} === 64'h0, "R11 acc", {acc_hi, acc_lo}, 64'h0);

    for (int op = 0; op < 8; op++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          run_op(3'(op), pick(ia), pick(ib), ((ia + ib) % 5) == 0, ((ia * 16 + ib) % 37) == 3);
        end
      end
    end

    // R10 clear while idle, then accumulate from zero
    run_op(3'b001, 32'h0000_1234, 32'h0000_4321, 1'b0, 1'b0);
    @(negedge clk); acc_clr = 1'b1;
    @(negedge clk); acc_clr = 1'b0;
    model_acc = 64'h0;
    chk({acc_hi, acc_lo} === 64'h0, "R10 idle clear", {acc_hi, acc_lo}, 64'h0);
    run_op(3'b011, 32'hFFFF_FFFE, 32'h8000_0000, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule